// File: doc/BRIEF.md
# Dual-Cell Boundary Register with Self-Test Generators

This block is the boundary register for one nine-bit slice of a bidirectional bus buffer. Every I/O position has two test cells, one facing the A bus and one facing the B bus, so test values can be observed on and forced onto either bus independently. A separate instruction decoder picks the mode, and a separate TAP controller supplies the capture, shift and update strobes and a one-cycle tick for each test clock spent in Run-Test/Idle. Everything is clocked by the test clock.

Besides the usual observe, drive, clamp and high-impedance behaviours, the cells can run on their own. The A-side shift cells can act as a masked signature compressor over the A pins. The B-side hold cells can act as a pseudo-random generator or a binary counter driving the B pins, and both can run together. A sample-and-toggle mode inverts every held output value on each idle tick. The functional path is a plain pass-through when no test instruction is active.

Top module: `bscan_dual_cell`

## Requirements
- R1: A synchronous active-high reset clears every shift cell, every hold cell and the one-bit bypass stage to 0. With mode 0 selected after reset, `tdo` is 0.
- R2: With mode 0 (sample), `a_out`/`b_out` equal `a_func`/`b_func`, and `a_oe`/`b_oe` equal `a_func_oe`/`b_func_oe`, whatever the hold cells contain.
- R3: On `capture_en` in any mode other than 2 and 3, A cells load `a_pin` and B cells load `b_pin`. On `shift_en` (without capture), data moves from `tdi` through B bit 1..9, then A bit 1..9, and `tdo` shows A bit 9. Capture wins over shift.
- R4: On `update_en` in any mode other than 2 and 3, the hold cells copy the shift cells. In modes 1 (drive) and 8 (toggle), the outputs present the hold cells and the enables follow `a_func_oe`/`b_func_oe`.
- R5: In mode 2 (clamp), `tdo` comes from the bypass stage. Capture loads it with 0, and shift loads it from `tdi`. Shift and hold cells ignore capture, shift, update and ticks. The outputs present the hold cells with the functional enables.
- R6: In mode 3 (isolate), both output enables are 0, the bypass stage is used as in R5, and all cells hold.
- R7: In mode 4 (signature), an idle tick replaces the A shift cells S with {S[8:1], S[9]^S[5]} XOR (`a_pin` AND the A hold cells), where the A hold cells act as the mask. B shift cells are unchanged. `a_oe`=0 and `b_oe`=1.
- R8: In mode 5 (pattern), an idle tick advances the B hold cells with the same shift-left feedback (bit 9 XOR bit 5 enters at bit 1). An all-zero value is replaced by 1, so the register never holds zero after a tick. `a_oe`=0, `b_oe`=1, and `b_out` shows the B hold cells.
- R9: In mode 6 (count), an idle tick adds 1 to the B hold cells, modulo 512, and `b_out` shows them. `a_oe`=0 and `b_oe`=1.
- R10: In mode 7, an idle tick applies R7 to the A shift cells and R9 to the B hold cells in the same cycle.
- R11: In mode 8 (toggle), an idle tick inverts all eighteen hold cells. Capture works as in R3.
- R12: An idle tick has no effect in a cycle where `capture_en`, `shift_en` or `update_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Mode from the instruction decoder (codes 0..8) |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| idle_tick | input | 1 | One tick per test clock in Run-Test/Idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| a_pin | input | 9 | Values observed at the A pins |
| b_pin | input | 9 | Values observed at the B pins |
| a_func | input | 9 | Functional data for the A pins |
| b_func | input | 9 | Functional data for the B pins |
| a_func_oe | input | 1 | Functional enable for the A drivers |
| b_func_oe | input | 1 | Functional enable for the B drivers |
| a_out | output | 9 | Data to the A pin drivers |
| b_out | output | 9 | Data to the B pin drivers |
| a_oe | output | 1 | A driver enable |
| b_oe | output | 1 | B driver enable |

## Verification
The assertions assume that the TAP controller raises at most one of capture, shift and update in a cycle. They also assume the mode holds one of the nine defined codes. The stimulus stays within this: it sets the mode only between operations, drives strobes one at a time, and breaks that rule on purpose only to combine an idle tick with another strobe when checking R12. The generator checks rely on seeds loaded through shift and update, including the all-zero seed and the counter wrap at 511.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int unsigned LANE_W  = 9;
    localparam int unsigned CHAIN_W = 2 * LANE_W;
    localparam int unsigned FB_HI   = LANE_W - 1;
    localparam int unsigned FB_LO   = 4;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        lane_t a;
        lane_t b;
    } cells_t;

    typedef enum logic [3:0] {
        MD_SAMPLE = 4'd0,
        MD_DRIVE  = 4'd1,
        MD_CLAMP  = 4'd2,
        MD_ISOL   = 4'd3,
        MD_SIG    = 4'd4,
        MD_PAT    = 4'd5,
        MD_COUNT  = 4'd6,
        MD_SIGCNT = 4'd7,
        MD_TOGGLE = 4'd8
    } mode_t;

    typedef enum logic [1:0] {
        GEN_NONE,
        GEN_PAT,
        GEN_COUNT,
        GEN_TOGGLE
    } gen_t;

    typedef enum logic [1:0] {
        OS_FUNC,
        OS_HOLD_FUNC_OE,
        OS_HOLD_OFF,
        OS_HOLD_SELF
    } outsel_t;

    typedef struct packed {
        logic    bypass;
        logic    sig;
        gen_t    gen;
        outsel_t outsel;
    } ctl_t;

    function automatic lane_t lane_lfsr(lane_t s);
        return {s[LANE_W-2:0], s[FB_HI] ^ s[FB_LO]};
    endfunction

    function automatic ctl_t mode_decode(mode_t m);
        ctl_t c;
        c.bypass = 1'b0;
        c.sig    = 1'b0;
        c.gen    = GEN_NONE;
        c.outsel = OS_FUNC;
        case (m)
            MD_DRIVE:  c.outsel = OS_HOLD_FUNC_OE;
            MD_CLAMP:  begin c.bypass = 1'b1; c.outsel = OS_HOLD_FUNC_OE; end
            MD_ISOL:   begin c.bypass = 1'b1; c.outsel = OS_HOLD_OFF; end
            MD_SIG:    begin c.sig = 1'b1; c.outsel = OS_HOLD_SELF; end
            MD_PAT:    begin c.gen = GEN_PAT; c.outsel = OS_HOLD_SELF; end
            MD_COUNT:  begin c.gen = GEN_COUNT; c.outsel = OS_HOLD_SELF; end
            MD_SIGCNT: begin c.sig = 1'b1; c.gen = GEN_COUNT; c.outsel = OS_HOLD_SELF; end
            MD_TOGGLE: begin c.gen = GEN_TOGGLE; c.outsel = OS_HOLD_FUNC_OE; end
            default:   c.outsel = OS_FUNC;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsc_chain.sv
module bsc_chain
    import bsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl,
    input  logic   capture_en,
    input  logic   shift_en,
    input  logic   step_en,
    input  logic   tdi,
    input  lane_t  a_pin,
    input  lane_t  b_pin,
    input  lane_t  mask,
    output cells_t sh_q,
    output logic   byp_q
);

    cells_t sh_d;
    logic   byp_d;

    always_comb begin
        sh_d  = sh_q;
        byp_d = byp_q;
        if (ctl.bypass) begin
            if (capture_en)    byp_d = 1'b0;
            else if (shift_en) byp_d = tdi;
        end else begin
            if (capture_en) begin
                sh_d.a = a_pin;
                sh_d.b = b_pin;
            end else if (shift_en) begin
                sh_d = cells_t'({sh_q[CHAIN_W-2:0], tdi});
            end else if (step_en && ctl.sig) begin
                sh_d.a = lane_lfsr(sh_q.a) ^ (a_pin & mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            byp_q <= 1'b0;
        end else begin
            sh_q  <= sh_d;
            byp_q <= byp_d;
        end
    end

    // R3: serial input lands in B bit 1
    a_r3_shift_entry: assert property (@(posedge clk) disable iff (rst)
        (!ctl.bypass && shift_en && !capture_en) |=> (sh_q[0] == $past(tdi)));

    // R5: cells frozen while the bypass path is in use
    a_r5_chain_frozen: assert property (@(posedge clk) disable iff (rst)
        ctl.bypass |=> $stable(sh_q));

    // R7: signature steps leave the B cells alone
    a_r7_b_side_kept: assert property (@(posedge clk) disable iff (rst)
        (!ctl.bypass && ctl.sig && step_en) |=> $stable(sh_q.b));

endmodule

// File: rtl/bsc_hold.sv
module bsc_hold
    import bsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl,
    input  logic   update_en,
    input  logic   step_en,
    input  cells_t sh_d,
    output cells_t up_q
);

    cells_t up_d;
    lane_t  pat_next;

    always_comb begin
        pat_next = (up_q.b == '0) ? lane_t'(1) : lane_lfsr(up_q.b);
    end

    always_comb begin
        up_d = up_q;
        if (!ctl.bypass) begin
            if (update_en) begin
                up_d = sh_d;
            end else if (step_en) begin
                case (ctl.gen)
                    GEN_PAT:    up_d.b = pat_next;
                    GEN_COUNT:  up_d.b = up_q.b + lane_t'(1);
                    GEN_TOGGLE: up_d   = ~up_q;
                    default:    up_d   = up_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) up_q <= '0;
        else     up_q <= up_d;
    end

    // R8: pattern generator never sits at zero after a tick
    a_r8_never_zero: assert property (@(posedge clk) disable iff (rst)
        (!ctl.bypass && ctl.gen == GEN_PAT && step_en && !update_en) |=> (up_q.b != '0));

    // R9: counter advances by one
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (!ctl.bypass && ctl.gen == GEN_COUNT && step_en && !update_en)
        |=> (up_q.b == lane_t'($past(up_q.b) + lane_t'(1))));

    // R11: toggle inverts every hold cell
    a_r11_toggle_all: assert property (@(posedge clk) disable iff (rst)
        (!ctl.bypass && ctl.gen == GEN_TOGGLE && step_en && !update_en)
        |=> (up_q == ~$past(up_q)));

    // R5: hold cells untouched on the bypass path
    a_r5_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        ctl.bypass |=> $stable(up_q));

endmodule

// File: rtl/bsc_pinmux.sv
module bsc_pinmux
    import bsc_pkg::*;
(
    input  ctl_t   ctl,
    input  cells_t up_q,
    input  cells_t sh_q,
    input  logic   byp_q,
    input  lane_t  a_func,
    input  lane_t  b_func,
    input  logic   a_func_oe,
    input  logic   b_func_oe,
    output lane_t  a_out,
    output lane_t  b_out,
    output logic   a_oe,
    output logic   b_oe,
    output logic   tdo
);

    always_comb begin
        tdo = ctl.bypass ? byp_q : sh_q[CHAIN_W-1];
        case (ctl.outsel)
            OS_HOLD_FUNC_OE: begin
                a_out = up_q.a;  b_out = up_q.b;
                a_oe  = a_func_oe; b_oe = b_func_oe;
            end
            OS_HOLD_OFF: begin
                a_out = up_q.a;  b_out = up_q.b;
                a_oe  = 1'b0;    b_oe  = 1'b0;
            end
            OS_HOLD_SELF: begin
                a_out = up_q.a;  b_out = up_q.b;
                a_oe  = 1'b0;    b_oe  = 1'b1;
            end
            default: begin
                a_out = a_func;  b_out = b_func;
                a_oe  = a_func_oe; b_oe = b_func_oe;
            end
        endcase
    end

endmodule

// File: rtl/bscan_dual_cell.sv
module bscan_dual_cell
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        mode,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              idle_tick,
    input  logic              tdi,
    output logic              tdo,
    input  logic [LANE_W-1:0] a_pin,
    input  logic [LANE_W-1:0] b_pin,
    input  logic [LANE_W-1:0] a_func,
    input  logic [LANE_W-1:0] b_func,
    input  logic              a_func_oe,
    input  logic              b_func_oe,
    output logic [LANE_W-1:0] a_out,
    output logic [LANE_W-1:0] b_out,
    output logic              a_oe,
    output logic              b_oe
);

    ctl_t   ctl;
    logic   step_en;
    cells_t sh_q;
    cells_t up_q;
    logic   byp_q;

    always_comb begin
        ctl     = mode_decode(mode_t'(mode));
        step_en = idle_tick && !capture_en && !shift_en && !update_en;
    end

    bsc_chain u_chain (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .step_en    (step_en),
        .tdi        (tdi),
        .a_pin      (a_pin),
        .b_pin      (b_pin),
        .mask       (up_q.a),
        .sh_q       (sh_q),
        .byp_q      (byp_q)
    );

    bsc_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .update_en (update_en),
        .step_en   (step_en),
        .sh_d      (sh_q),
        .up_q      (up_q)
    );

    bsc_pinmux u_pinmux (
        .ctl       (ctl),
        .up_q      (up_q),
        .sh_q      (sh_q),
        .byp_q     (byp_q),
        .a_func    (a_func),
        .b_func    (b_func),
        .a_func_oe (a_func_oe),
        .b_func_oe (b_func_oe),
        .a_out     (a_out),
        .b_out     (b_out),
        .a_oe      (a_oe),
        .b_oe      (b_oe),
        .tdo       (tdo)
    );

    // R1: serial output quiet right after reset in sample mode
    a_r1_tdo_reset: assert property (@(posedge clk)
        (rst && mode == 4'd0) |=> (tdo == 1'b0));

    // R2: sample mode is transparent
    a_r2_sample_pass: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd0) |-> (a_out == a_func && b_out == b_func));

    // R6: isolate mode turns both drivers off
    a_r6_isolate_off: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd3) |-> (!a_oe && !b_oe));

    // R12: a tick alongside a strobe does not alter the hold cells
    a_r12_tick_masked: assert property (@(posedge clk) disable iff (rst)
        (idle_tick && (capture_en || shift_en) && !update_en) |=> $stable(up_q));

endmodule

// File: tb/test_bscan_dual_cell.sv
module test_bscan_dual_cell;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] mode;
    logic       capture_en, shift_en, update_en, idle_tick, tdi;
    logic       tdo;
    logic [8:0] a_pin, b_pin, a_func, b_func;
    logic       a_func_oe, b_func_oe;
    logic [8:0] a_out, b_out;
    logic       a_oe, b_oe;

    always #10 clk = ~clk;

    bscan_dual_cell i_bscan_dual_cell (
        .clk(clk), .rst(rst), .mode(mode),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .idle_tick(idle_tick), .tdi(tdi), .tdo(tdo),
        .a_pin(a_pin), .b_pin(b_pin), .a_func(a_func), .b_func(b_func),
        .a_func_oe(a_func_oe), .b_func_oe(b_func_oe),
        .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    int    cycles  = 0;
    bit    done    = 0;

    // reference state: sc = shift cells (index 0..8 = B1..B9, 9..17 = A1..A9)
    bit sc[18];
    bit hc[18];
    bit bp;

    function automatic int lane_val(bit v[18], int base);
        int r = 0;
        for (int i = 0; i < 9; i++) if (v[base+i]) r += (1 << i);
        return r;
    endfunction

    function automatic int lfsr_ref(int s);
        int fb = ((s >> 8) & 1) ^ ((s >> 4) & 1);
        return ((s << 1) | fb) & 511;
    endfunction

    task automatic model_step();
        bit nsc[18];
        bit nhc[18];
        bit nbp;
        bit bypm, stp;
        int v;
        nsc = sc; nhc = hc; nbp = bp;
        if (rst) begin
            for (int i = 0; i < 18; i++) begin nsc[i] = 0; nhc[i] = 0; end
            nbp = 0;
        end else begin
            bypm = (mode == 2) || (mode == 3);
            stp  = idle_tick && !capture_en && !shift_en && !update_en;
            if (bypm) begin
                if (capture_en) nbp = 0;
                else if (shift_en) nbp = tdi;
            end else begin
                if (capture_en) begin
                    for (int i = 0; i < 9; i++) begin nsc[i] = b_pin[i]; nsc[9+i] = a_pin[i]; end
                end else if (shift_en) begin
                    nsc[0] = tdi;
                    for (int i = 1; i < 18; i++) nsc[i] = sc[i-1];
                end else if (stp && (mode == 4 || mode == 7)) begin
                    v = lfsr_ref(lane_val(sc, 9)) ^ (int'(a_pin) & lane_val(hc, 9));
                    for (int i = 0; i < 9; i++) nsc[9+i] = v[i];
                end
                if (update_en) begin
                    nhc = sc;
                end else if (stp) begin
                    if (mode == 5) begin
                        v = lane_val(hc, 0);
                        v = (v == 0) ? 1 : lfsr_ref(v);
                        for (int i = 0; i < 9; i++) nhc[i] = v[i];
                    end else if (mode == 6 || mode == 7) begin
                        v = (lane_val(hc, 0) + 1) % 512;
                        for (int i = 0; i < 9; i++) nhc[i] = v[i];
                    end else if (mode == 8) begin
                        for (int i = 0; i < 18; i++) nhc[i] = !hc[i];
                    end
                end
            end
        end
        sc = nsc; hc = nhc; bp = nbp;
    endtask

    task automatic check(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int ea, eb, eao, ebo, et;
        et = ((mode == 2) || (mode == 3)) ? int'(bp) : int'(sc[17]);
        if (mode == 0) begin
            ea = a_func; eb = b_func; eao = a_func_oe; ebo = b_func_oe;
        end else begin
            ea = lane_val(hc, 9); eb = lane_val(hc, 0);
            if (mode == 1 || mode == 2 || mode == 8) begin eao = a_func_oe; ebo = b_func_oe; end
            else if (mode == 3) begin eao = 0; ebo = 0; end
            else begin eao = 0; ebo = 1; end
        end
        check("a_out", a_out, ea);
        check("b_out", b_out, eb);
        check("a_oe", a_oe, eao);
        check("b_oe", b_oe, ebo);
        check("tdo", tdo, et);
    endtask

    task automatic cyc(bit c, bit s, bit u, bit t, bit d);
        capture_en = c; shift_en = s; update_en = u; idle_tick = t; tdi = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic load_chain(logic [17:0] v);
        for (int i = 17; i >= 0; i--) cyc(0, 1, 0, 0, v[i]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        rst = 1; mode = 0; capture_en = 0; shift_en = 0; update_en = 0; idle_tick = 0; tdi = 0;
        a_pin = 9'h0; b_pin = 9'h0; a_func = 9'h0A5; b_func = 9'h15A;
        a_func_oe = 1; b_func_oe = 0;
        for (int i = 0; i < 18; i++) begin sc[i] = 0; hc[i] = 0; end
        bp = 0;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        rst = 0;
        cyc(0, 0, 0, 0, 0);
        check("tdo after reset", tdo, 0);

        // R2: sample mode transparency with several functional patterns
        cur_req = "R2";
        a_func = 9'h1FF; b_func = 9'h000; a_func_oe = 0; b_func_oe = 1;
        cyc(0, 0, 0, 0, 0);
        a_func = 9'h123; b_func = 9'h0DE; a_func_oe = 1; b_func_oe = 1;
        cyc(0, 0, 0, 1, 0);

        // R3: capture and serial readout order
        cur_req = "R3";
        a_pin = 9'h101; b_pin = 9'h0C3;
        cyc(1, 0, 0, 0, 0);
        check("A9 at tdo after capture", tdo, 1);
        for (int i = 0; i < 18; i++) cyc(0, 1, 0, 0, i[0]);
        cyc(1, 1, 0, 0, 1);   // capture wins over shift

        // R4: update into hold cells, drive mode
        cur_req = "R4";
        mode = 1;
        load_chain(18'h2A5C3);
        cyc(0, 0, 1, 0, 0);
        check("b_out after update", b_out, 18'h2A5C3 & 9'h1FF);
        a_func_oe = 0; b_func_oe = 1;
        cyc(0, 0, 0, 0, 0);

        // R11 and R12: toggle mode
        cur_req = "R11";
        mode = 8;
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        a_pin = 9'h055; b_pin = 9'h1AA;
        cyc(1, 0, 0, 0, 0);
        cur_req = "R12";
        cyc(1, 0, 0, 1, 0);
        cyc(0, 1, 0, 1, 1);
        cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 0);

        // R5: clamp uses bypass, cells frozen
        cur_req = "R5";
        mode = 2;
        cyc(0, 1, 0, 0, 1);
        check("bypass carries tdi", tdo, 1);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 1, 0, 0, 1);
        cyc(1, 0, 0, 0, 0);
        check("bypass capture zero", tdo, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);

        // R6: isolate
        cur_req = "R6";
        mode = 3; a_func_oe = 1; b_func_oe = 1;
        cyc(0, 1, 0, 0, 1);
        cyc(0, 0, 1, 0, 0);
        check("a_oe isolate", a_oe, 0);

        // R7: signature with mask from A hold cells
        cur_req = "R7";
        mode = 4;
        load_chain(18'h1E0F0);     // A hold = 0x0F0 mask, B hold = 0x0F0
        cyc(0, 0, 1, 0, 0);
        load_chain(18'h00000);
        for (int k = 0; k < 12; k++) begin
            a_pin = 9'((k * 37 + 11) & 511);
            cyc(0, 0, 0, 1, 0);
        end
        load_chain(18'h3FE00);     // full mask
        cyc(0, 0, 1, 0, 0);
        for (int k = 0; k < 10; k++) begin
            a_pin = 9'((k * 91 + 5) & 511);
            cyc(0, 0, 0, 1, 0);
        end
        for (int i = 0; i < 18; i++) cyc(0, 1, 0, 0, 0);

        // R8: pattern generation, zero seed and live seed
        cur_req = "R8";
        mode = 5;
        load_chain(18'h00000);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        check("zero seed replaced", b_out, 1);
        for (int k = 0; k < 30; k++) cyc(0, 0, 0, 1, 0);
        load_chain(18'h00111);
        cyc(0, 0, 1, 0, 0);
        for (int k = 0; k < 20; k++) cyc(0, 0, 0, 1, 0);

        // R9: counting and wrap
        cur_req = "R9";
        mode = 6;
        load_chain(18'h001FE);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        check("count wrap", b_out, 0);
        cyc(0, 0, 0, 1, 0);

        // R10: signature and count together
        cur_req = "R10";
        mode = 7;
        load_chain(18'h3FE05);
        cyc(0, 0, 1, 0, 0);
        for (int k = 0; k < 8; k++) begin
            a_pin = 9'((k * 53 + 7) & 511);
            cyc(0, 0, 0, 1, 0);
        end
        for (int i = 0; i < 18; i++) cyc(0, 1, 0, 0, 0);

        // R2 again: back to sample with non-zero hold cells
        cur_req = "R2";
        mode = 0;
        cyc(0, 0, 0, 0, 0);

        finish_run();
    end

endmodule